// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers a 32-bit word of level-sensitive interrupt lines. It splits them into four slices of eight and presents one request per slice to an upstream interrupt controller. Group g owns bits g*8 through g*8+7 of the word. The group's request is high whenever at least one of its sources is both active and enabled.

Software controls the enables through a small register port with valid, write, address and data signals. One address sets enable bits wherever the written word carries a 1. A second address clears enable bits the same way. A third address returns the enabled, active sources. No interrupt state is latched: a request follows its source and drops once the peripheral releases the line. For each group, the block also outputs the position of the lowest-numbered active, enabled source, so a handler can serve that source first without scanning the bits.

Top module: `irq_group_merger`

## Requirements
- R1: After reset, all enables are 0, every group request is 0, every index is 0 and the read data is 0, even while all sources are high.
- R2: A write to offset 0x0 sets each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R3: A write to offset 0x4 clears each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R4: A read of offset 0xC returns (sources AND enables) on the read data one cycle later. A disabled source reads 0.
- R5: Request bit g equals the OR of (source AND enable) over group g's eight bits, as sampled at the previous clock edge.
- R6: Group g corresponds to word bits 8g to 8g+7. Enabling a bit affects only the request and index of the group that owns it.
- R7: Sources are levels and nothing latches them. A request falls in the cycle after its last enabled source goes low.
- R8: Index output bits [3g+2:3g] give the lowest bit position within group g that is active and enabled, registered like the request. The index is 0 when the group has none.
- R9: A read of any offset other than 0xC returns 0. A write to any offset other than 0x0 or 0x4 (for example 0x8) leaves all enables unchanged.
- R10: Writing a group's 8-bit mask (0xFF shifted left by 8g) to offset 0x4 disables that whole group and leaves every other group's enables untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 32 | Level interrupt sources, already synchronous to clk |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read strobe, held until the next read |
| grp_req | output | 4 | Combined request per group |
| grp_idx | output | 12 | Lowest active enabled position per group, 3 bits each |

## Verification
The bench uses the default parameters: a 32-bit word, 8-bit groups and 4-bit byte offsets. This gives four groups with 3-bit indices. With these values the first and last bit of every slice can be reached, including bits 0, 7, 8 and 31, as well as the one undefined offset inside the window, 0x8. Directed steps cover several sources active in one group, which tests lowest-first selection, and whole-group clear masks. A pseudo-random run then mixes source patterns with accesses to all four offsets and checks the result against a bench model of the enables.

// File: rtl/irq_group_merger.sv
module irq_group_merger #(
  parameter int DATA_W = 32,
  parameter int GRP_W  = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] SET_OFS  = 4'h0,
  parameter logic [ADDR_W-1:0] CLR_OFS  = 4'h4,
  parameter logic [ADDR_W-1:0] STAT_OFS = 4'hC,
  localparam int NGRP  = DATA_W / GRP_W,
  localparam int IDX_W = $clog2(GRP_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DATA_W-1:0]     src_lvl,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NGRP-1:0]       grp_req,
  output logic [NGRP*IDX_W-1:0] grp_idx
);

  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] live;

  wire wr_set = bus_valid & bus_write & (bus_addr == SET_OFS);
  wire wr_clr = bus_valid & bus_write & (bus_addr == CLR_OFS);
  wire rd_any = bus_valid & ~bus_write;

  assign live = src_lvl & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_set) en_q <= en_q | bus_wdata;
    else if (wr_clr) en_q <= en_q & ~bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_any) bus_rdata <= (bus_addr == STAT_OFS) ? live : '0;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP_W-1:0] slice;
    logic [IDX_W-1:0] low;

    assign slice = live[g*GRP_W +: GRP_W];

    always_comb begin
      low = '0;
      for (int i = GRP_W - 1; i >= 0; i--)
        if (slice[i]) low = IDX_W'(i);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        grp_req[g]                 <= 1'b0;
        grp_idx[g*IDX_W +: IDX_W]  <= '0;
      end else begin
        grp_req[g]                 <= |slice;
        grp_idx[g*IDX_W +: IDX_W]  <= low;
      end
    end

    // R5
    req_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> grp_req[g] == |($past(src_lvl[g*GRP_W +: GRP_W]) & $past(en_q[g*GRP_W +: GRP_W])));

    // R8
    idx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_req[g] |-> grp_idx[g*IDX_W +: IDX_W] == '0);
  end

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (en_q & $past(bus_wdata)) == $past(bus_wdata));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (en_q & $past(bus_wdata)) == '0);

  // R9
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set | wr_clr) |=> $stable(en_q));

  // R9
  rd_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && bus_addr != STAT_OFS) |=> bus_rdata == '0);

endmodule

// File: tb/tb_irq_group_merger.sv
`timescale 1ns/1ps
module tb_irq_group_merger;
  logic clk = 0, rst_n = 0;
  logic [31:0] src = '0, wdata = '0;
  logic valid = 0, write = 0;
  logic [3:0] addr = '0;
  logic [31:0] rdata;
  logic [3:0] req;
  logic [11:0] idx;

  always #2 clk = ~clk;

  irq_group_merger dut (
    .clk(clk), .rst_n(rst_n), .src_lvl(src),
    .bus_valid(valid), .bus_write(write), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .grp_req(req), .grp_idx(idx));

  typedef struct {
    string       tag;
    logic [3:0]  req;
    logic [11:0] idx;
    logic        rd;
    logic [31:0] rdata;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic [31:0] en_m = '0;
  logic [31:0] rd_m = '0;
  bit done = 0;

  function automatic exp_t predict(string tag, logic [31:0] v, logic rd, logic [31:0] r);
    exp_t e;
    e.tag = tag; e.rd = rd; e.rdata = r; e.req = '0; e.idx = '0;
    for (int g = 0; g < 4; g++) begin
      e.req[g] = |v[g*8 +: 8];
      for (int i = 7; i >= 0; i--)
        if (v[g*8+i]) e.idx[g*3 +: 3] = 3'(i);
    end
    return e;
  endfunction

  // op: 0 idle, 1 write, 2 read
  task automatic step(input logic [31:0] s, input int op, input logic [3:0] a,
                      input logic [31:0] d, input string tag);
    logic rd;
    @(negedge clk);
    src = s;
    rd = 0;
    if (op != 0) begin
      valid = 1; write = (op == 1); addr = a; wdata = d;
    end
    if (op == 2) begin
      rd = 1;
      rd_m = (a == 4'hC) ? (s & en_m) : 32'h0;
    end
    if (op == 1) begin
      if (a == 4'h0) en_m = en_m | d;
      else if (a == 4'h4) en_m = en_m & ~d;
    end
    @(negedge clk);
    valid = 0; write = 0;
    @(posedge clk);
    q.push_back(predict(tag, s & en_m, rd, rd_m));
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (req !== e.req || idx !== e.idx || (e.rd && rdata !== e.rdata)) begin
        fails++;
        $display("FAIL %s: req=%h idx=%h rdata=%h expected req=%h idx=%h rdata=%h",
                 e.tag, req, idx, rdata, e.req, e.idx, e.rdata);
      end
    end
  end

  initial begin
    logic [31:0] lfsr;
    src = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    q.push_back(predict("R1", 32'h0, 1'b1, 32'h0));

    step(32'hFFFF_FFFF, 1, 4'h0, 32'h0000_0000, "R2");
    step(32'hFFFF_FFFF, 1, 4'h0, 32'h0000_0080, "R2");
    step(32'hFFFF_FFFF, 1, 4'h0, 32'h0000_0001, "R8");
    step(32'hFFFF_FFFF, 2, 4'hC, 32'h0, "R4");
    step(32'h0000_0080, 0, 4'h0, 32'h0, "R7");
    step(32'h0000_0000, 0, 4'h0, 32'h0, "R7");
    step(32'hFFFF_FFFF, 1, 4'h0, 32'h8000_0100, "R6");
    step(32'hFFFF_FFFF, 2, 4'hC, 32'h0, "R4");
    step(32'h0000_0000, 2, 4'hC, 32'h0, "R4");
    step(32'hFFFF_FFFF, 1, 4'h4, 32'h0000_0000, "R3");
    step(32'hFFFF_FFFF, 1, 4'h4, 32'h0000_0001, "R3");
    step(32'hFFFF_FFFF, 1, 4'h8, 32'hFFFF_FFFF, "R9");
    step(32'hFFFF_FFFF, 2, 4'h8, 32'h0, "R9");
    step(32'hFFFF_FFFF, 2, 4'hC, 32'h0, "R9");
    step(32'hFFFF_FFFF, 1, 4'h0, 32'hFFFF_FFFF, "R6");
    step(32'h4020_1008, 0, 4'h0, 32'h0, "R8");
    step(32'hC0E0_F0F8, 2, 4'hC, 32'h0, "R8");
    step(32'hFFFF_FFFF, 1, 4'h4, 32'h0000_FF00, "R10");
    step(32'hFFFF_FFFF, 2, 4'hC, 32'h0, "R10");
    step(32'hFFFF_FFFF, 1, 4'h4, 32'hFF00_0000, "R10");
    step(32'hFFFF_FFFF, 2, 4'hC, 32'h0, "R10");

    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 60; n++) begin
      logic [31:0] s, d;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      s = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      d = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      step(s, int'(lfsr[1:0] % 3), {lfsr[5:4], 2'b00}, d, "R5");
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule